// File: doc/BRIEF.md
# Pointer-indexed control register port

This block gives a host a byte-wide path into a bank of seventeen internal write registers and eight external status bytes while using only two host locations. The control location carries register traffic and the data location carries character traffic. A control write made while the pointer is zero goes into register 0, and its low bits load a pointer. The next control access, read or write, then lands on the register that the pointer names. After that access the pointer falls back to zero. This lets register 0 be reached with a single access at any time the pointer is idle.

A command field inside the register 0 byte can lift the pointer into the upper half of the bank. A flag bit in register 15 turns pointer value 7 into a route to an extra register at index 16. Readback is partial. Indices 12, 13 and 15 return the stored baud time-constant bytes and the register 15 value. Every other index returns a status byte chosen by the index modulo 8, so the upper half aliases the lower half. The serial engine attaches to the stored register outputs, the status inputs and two character streams.

The character streams use valid/ready and the block holds no buffer. A data-location write is offered on `tx_valid` in the same cycle, and the transfer counts only in a cycle where `tx_ready` is also high. A host that sees `tx_ready` low must hold its write for another cycle. A data-location read raises `rx_ready` for that cycle. Whatever `rx_data` shows is captured only when `rx_valid` is high.

Top module: `ixreg_port`

## Requirements
- R1: A synchronous reset clears all seventeen write registers to 0x00, clears the pointer to 0 and drops `rd_vld`.
- R2: A control write while the pointer is 0 stores the byte in register 0 and loads the pointer with bits 2..0. When bits 5..3 equal 3'b001 (byte 0x08 with those bits), 8 is added, so pointer values 0..7 reach registers 8..15.
- R3: A control write while the pointer is nonzero stores the byte in the register the pointer names, and the pointer becomes 0.
- R4: A control read returns the selected register on `rdata` with `rd_vld` high one cycle later, and the pointer becomes 0.
- R5: Reads at indices 12, 13 and 15 return the stored write registers 12, 13 and 15.
- R6: A read at any other index returns status byte (index mod 8) from `stat_i`, where byte k sits in bits 8k+7..8k.
- R7: When bit 0 of write register 15 is 1, a pointed write at pointer 7 goes to register 16 and register 7 is left unchanged. When that bit is 0, the write goes to register 7.
- R8: A control read while the pointer is 0 returns status byte 0 and leaves every register and the pointer unchanged.
- R9: A data-location write drives `tx_valid` high with `tx_data` equal to `wdata` in the same cycle and changes no register.
- R10: A data-location read drives `rx_ready` high in that cycle. One cycle later `rdata` holds `rx_data` if `rx_valid` was high and 0x00 if it was low, with `rd_vld` high.
- R11: Only one host access is served per cycle, in the priority order control write, control read, data write, data read. Lower-priority strobes in the same cycle have no effect.
- R12: `wreg_flat` exposes register k at bits 8k+7..8k for k = 0..16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Host write strobe, control location |
| ctl_rd | input | 1 | Host read strobe, control location |
| dat_wr | input | 1 | Host write strobe, data location |
| dat_rd | input | 1 | Host read strobe, data location |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, valid with rd_vld |
| rd_vld | output | 1 | Read result present, one cycle after a served read |
| stat_i | input | 64 | Eight status bytes from the serial engine |
| wreg_flat | output | 136 | All seventeen write registers |
| tx_valid | output | 1 | Transmit character offered |
| tx_ready | input | 1 | Transmit sink accepts |
| tx_data | output | 8 | Transmit character |
| rx_valid | input | 1 | Receive character present |
| rx_ready | output | 1 | Receive character taken |
| rx_data | input | 8 | Receive character |

## Verification
The host can raise a pointed control access and a data-location access in the same cycle. When that happens the control access must win, the pointer must still return to zero, and the character stream must stay untouched. The bench provokes this with directed cycles that assert all four strobes while the pointer is nonzero. It also runs random cycles in which any subset of the strobes is high together. A reference model applies the stated priority and judges the outcome cycle by cycle against the stream handshakes, the read result and the full register image.

// File: rtl/ixreg_pkg.sv
package ixreg_pkg;
  localparam int DW      = 8;
  localparam int NLOW    = 8;
  localparam int NBASE   = 2 * NLOW;
  localparam int NWREG   = NBASE + 1;
  localparam int XREG    = NBASE;
  localparam int XALIAS  = 7;
  localparam int XEN_BIT = 0;
  localparam int BAUD_L  = 12;
  localparam int BAUD_H  = 13;
  localparam int ECHO    = 15;
  localparam int NSTAT   = 8;
  localparam logic [2:0] CMD_HI = 3'b001;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_CW,
    ACC_CR,
    ACC_DW,
    ACC_DR
  } acc_e;
endpackage

// File: rtl/ixreg_arb.sv
module ixreg_arb
  import ixreg_pkg::*;
(
  input  logic ctl_wr,
  input  logic ctl_rd,
  input  logic dat_wr,
  input  logic dat_rd,
  output acc_e acc
);
  always_comb begin
    if (ctl_wr)      acc = ACC_CW;
    else if (ctl_rd) acc = ACC_CR;
    else if (dat_wr) acc = ACC_DW;
    else if (dat_rd) acc = ACC_DR;
    else             acc = ACC_IDLE;
  end
endmodule

// File: rtl/ixreg_ptr.sv
module ixreg_ptr
  import ixreg_pkg::*;
#(
  parameter int W     = DW,
  parameter int NL    = NLOW,
  parameter int NW    = NWREG,
  parameter int ALIAS = XALIAS,
  parameter int XIDX  = XREG
) (
  input  logic               clk,
  input  logic               rst,
  input  acc_e               acc,
  input  logic [W-1:0]       wdata,
  input  logic               ext_en,
  output logic [$clog2(NW)-1:0] ptr_q,
  output logic               wr_go,
  output logic [$clog2(NW)-1:0] wr_idx
);
  localparam int PW = $clog2(NW);
  localparam int LW = $clog2(NL);

  logic [PW-1:0] tgt;
  logic          hi_sel;
  logic [PW-1:0] ptr_load;

  assign hi_sel   = (wdata[LW+2:LW] == CMD_HI);
  assign ptr_load = PW'(wdata[LW-1:0]) + (hi_sel ? PW'(NL) : PW'(0));

  always_comb begin
    tgt = ptr_q;
    if (ptr_q == PW'(ALIAS) && ext_en) tgt = PW'(XIDX);
  end

  assign wr_go  = (acc == ACC_CW);
  assign wr_idx = (ptr_q == '0) ? '0 : tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (acc == ACC_CW && ptr_q == '0) begin
      ptr_q <= ptr_load;
    end else if (acc == ACC_CW || acc == ACC_CR) begin
      ptr_q <= '0;
    end
  end
endmodule

// File: rtl/ixreg_bank.sv
module ixreg_bank
  import ixreg_pkg::*;
#(
  parameter int W  = DW,
  parameter int NW = NWREG
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_go,
  input  logic [$clog2(NW)-1:0] wr_idx,
  input  logic [W-1:0]          wdata,
  output logic [NW*W-1:0]       wflat
);
  localparam int PW = $clog2(NW);

  for (genvar g = 0; g < NW; g++) begin : g_reg
    logic [W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst)                                r_q <= '0;
      else if (wr_go && wr_idx == PW'(g))     r_q <= wdata;
    end
    assign wflat[g*W +: W] = r_q;
  end
endmodule

// File: rtl/ixreg_rmux.sv
module ixreg_rmux
  import ixreg_pkg::*;
#(
  parameter int W  = DW,
  parameter int NW = NWREG,
  parameter int NS = NSTAT,
  parameter int NB = NBASE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  acc_e                  acc,
  input  logic [$clog2(NW)-1:0] ptr_q,
  input  logic [NW*W-1:0]       wflat,
  input  logic [NS*W-1:0]       stat_i,
  input  logic                  rx_valid,
  input  logic [W-1:0]          rx_data,
  output logic [W-1:0]          rdata,
  output logic                  rd_vld
);
  localparam int IW = $clog2(NB);
  localparam int SW = $clog2(NS);

  logic [IW-1:0] idx;
  logic [W-1:0]  csel;

  assign idx = ptr_q[IW-1:0];

  always_comb begin
    if (idx == IW'(BAUD_L))      csel = wflat[BAUD_L*W +: W];
    else if (idx == IW'(BAUD_H)) csel = wflat[BAUD_H*W +: W];
    else if (idx == IW'(ECHO))   csel = wflat[ECHO*W +: W];
    else                         csel = stat_i[idx[SW-1:0]*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= (acc == ACC_CR) || (acc == ACC_DR);
      if (acc == ACC_CR)      rdata <= csel;
      else if (acc == ACC_DR) rdata <= rx_valid ? rx_data : '0;
    end
  end
endmodule

// File: rtl/ixreg_port.sv
module ixreg_port
  import ixreg_pkg::*;
#(
  parameter int W  = DW,
  parameter int NW = NWREG,
  parameter int NS = NSTAT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic          ctl_rd,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          rd_vld,
  input  logic [NS*W-1:0] stat_i,
  output logic [NW*W-1:0] wreg_flat,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [W-1:0]  tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [W-1:0]  rx_data
);
  localparam int PW = $clog2(NW);

  acc_e          acc;
  logic [PW-1:0] ptr_q;
  logic          wr_go;
  logic [PW-1:0] wr_idx;
  logic          ext_en;
  logic          tx_taken;

  ixreg_arb u_arb (
    .ctl_wr (ctl_wr),
    .ctl_rd (ctl_rd),
    .dat_wr (dat_wr),
    .dat_rd (dat_rd),
    .acc    (acc)
  );

  assign ext_en = wreg_flat[ECHO*W + XEN_BIT];

  ixreg_ptr #(.W(W), .NW(NW)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .acc    (acc),
    .wdata  (wdata),
    .ext_en (ext_en),
    .ptr_q  (ptr_q),
    .wr_go  (wr_go),
    .wr_idx (wr_idx)
  );

  ixreg_bank #(.W(W), .NW(NW)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_go  (wr_go),
    .wr_idx (wr_idx),
    .wdata  (wdata),
    .wflat  (wreg_flat)
  );

  ixreg_rmux #(.W(W), .NW(NW), .NS(NS)) u_rmux (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .ptr_q    (ptr_q),
    .wflat    (wreg_flat),
    .stat_i   (stat_i),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rdata    (rdata),
    .rd_vld   (rd_vld)
  );

  assign tx_valid = (acc == ACC_DW);
  assign tx_data  = wdata;
  assign rx_ready = (acc == ACC_DR);
  assign tx_taken = tx_valid & tx_ready;

  logic unused_ok;
  assign unused_ok = tx_taken;
endmodule

// File: rtl/ixreg_port_chk.sv
module ixreg_port_chk #(
  parameter int PW = 5,
  parameter int FW = 136
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_wr,
  input logic          ctl_rd,
  input logic          dat_wr,
  input logic          dat_rd,
  input logic          tx_valid,
  input logic          rx_ready,
  input logic          rd_vld,
  input logic [PW-1:0] ptr_q,
  input logic [FW-1:0] wreg_flat
);
  // R3 / R4: a pointed control access sends the pointer home
  a_r3_ptr_home: assert property (@(posedge clk) disable iff (rst)
    ((ctl_wr || ctl_rd) && ptr_q != '0) |=> (ptr_q == '0));

  // R8: idle-pointer control read touches no state
  a_r8_dummy_read: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && ctl_rd && ptr_q == '0) |=> (ptr_q == '0 && $stable(wreg_flat)));

  // R4 / R10: a served read yields a result next cycle
  a_r4_rd_valid: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && (ctl_rd || (!dat_wr && dat_rd))) |=> rd_vld);

  // R11: no read result when the read was outranked or absent
  a_r11_no_read: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr || (!ctl_rd && (dat_wr || !dat_rd))) |=> !rd_vld);

  // R11: stream strobes only when the data access won
  a_r11_tx_grant: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (dat_wr && !ctl_wr && !ctl_rd));
  a_r11_rx_grant: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (dat_rd && !dat_wr && !ctl_wr && !ctl_rd));
  a_r11_one_stream: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_valid, rx_ready}));

  // R9: registers change only through control writes
  a_r9_no_state: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> $stable(wreg_flat));
endmodule

bind ixreg_port ixreg_port_chk #(.PW($clog2(NW)), .FW(NW*W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_wr    (ctl_wr),
  .ctl_rd    (ctl_rd),
  .dat_wr    (dat_wr),
  .dat_rd    (dat_rd),
  .tx_valid  (tx_valid),
  .rx_ready  (rx_ready),
  .rd_vld    (rd_vld),
  .ptr_q     (ptr_q),
  .wreg_flat (wreg_flat)
);

// File: tb/ixreg_port_bench.sv
`timescale 1ns/1ps
module ixreg_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 0, ctl_rd = 0, dat_wr = 0, dat_rd = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic        rd_vld;
  logic [63:0] stat_i;
  logic [135:0] wreg_flat;
  logic        tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic [7:0]  tx_data, rx_data = 0;

  logic [7:0] stat_b [8];
  logic [7:0] ew [17];
  int         eptr;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  for (genvar k = 0; k < 8; k++) begin : g_st
    assign stat_i[k*8 +: 8] = stat_b[k];
  end

  ixreg_port u_ixreg_port (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .wdata(wdata), .rdata(rdata),
    .rd_vld(rd_vld), .stat_i(stat_i), .wreg_flat(wreg_flat),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input int idx);
    if (idx == 12 || idx == 13 || idx == 15) return ew[idx];
    return stat_b[idx % 8];
  endfunction

  function automatic logic [135:0] m_flat();
    logic [135:0] f;
    for (int k = 0; k < 17; k++) f[k*8 +: 8] = ew[k];
    return f;
  endfunction

  task automatic op(input bit cw, input bit cr, input bit dw, input bit dr,
                    input logic [7:0] wd, input bit txr, input bit rxv,
                    input logic [7:0] rxd, input string tag);
    logic [7:0] e_rd;
    bit e_vld, e_tx, e_rx;
    int tgt;
    ctl_wr = cw; ctl_rd = cr; dat_wr = dw; dat_rd = dr;
    wdata = wd; tx_ready = txr; rx_valid = rxv; rx_data = rxd;
    e_tx = dw && !cw && !cr;
    e_rx = dr && !cw && !cr && !dw;
    e_vld = 0; e_rd = 0;
    if (cw) begin
      if (eptr == 0) begin
        ew[0] = wd;
        eptr = int'(wd[2:0]) + ((wd[5:3] == 3'b001) ? 8 : 0);
      end else begin
        tgt = (eptr == 7 && ew[15][0]) ? 16 : eptr;
        ew[tgt] = wd;
        eptr = 0;
      end
    end else if (cr) begin
      e_vld = 1; e_rd = m_read(eptr % 16); eptr = 0;
    end else if (dr && !dw) begin
      e_vld = 1; e_rd = rxv ? rxd : 8'h00;
    end
    #1;
    chk(tx_valid == e_tx, tag, "tx_valid", 136'(tx_valid), 136'(e_tx));
    if (e_tx) chk(tx_data == wd, tag, "tx_data", 136'(tx_data), 136'(wd));
    chk(rx_ready == e_rx, tag, "rx_ready", 136'(rx_ready), 136'(e_rx));
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0; ctl_rd = 0; dat_wr = 0; dat_rd = 0;
    chk(rd_vld == e_vld, tag, "rd_vld", 136'(rd_vld), 136'(e_vld));
    if (e_vld) chk(rdata == e_rd, tag, "rdata", 136'(rdata), 136'(e_rd));
    chk(wreg_flat == m_flat(), tag, "wreg_flat", wreg_flat, m_flat());
  endtask

  task automatic cwr(input logic [7:0] v, input string tag);
    op(1, 0, 0, 0, v, 0, 0, 8'h00, tag);
  endtask
  task automatic crd(input string tag);
    op(0, 1, 0, 0, 8'h00, 0, 0, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 8; k++) stat_b[k] = 8'h40 + 8'(k * 17);
    for (int k = 0; k < 17; k++) ew[k] = 8'h00;
    eptr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(wreg_flat == '0, "R1", "wreg_flat", wreg_flat, '0);
    chk(rd_vld == 1'b0, "R1", "rd_vld", 136'(rd_vld), 136'(0));
    // R8: idle-pointer reads return status 0, change nothing
    crd("R8"); crd("R8");
    // R2 + R3 + R5: baud bytes via upper half pointer
    cwr(8'h0C, "R2"); cwr(8'h34, "R3");
    cwr(8'h0D, "R2"); cwr(8'h12, "R3");
    cwr(8'h0C, "R2"); crd("R5");
    cwr(8'h0D, "R2"); crd("R5");
    // R6: status index and upper-half alias
    cwr(8'h02, "R2"); crd("R6");
    cwr(8'h0A, "R2"); crd("R6");
    cwr(8'h0E, "R2"); crd("R6");
    // R7: extra register routing
    cwr(8'h0F, "R2"); cwr(8'h01, "R3");
    cwr(8'h0F, "R2"); crd("R5");
    cwr(8'h07, "R2"); cwr(8'hA5, "R7");
    cwr(8'h0F, "R2"); cwr(8'h00, "R7");
    cwr(8'h07, "R2"); cwr(8'h5A, "R7");
    // R12: register 0 image with command bits
    cwr(8'h30, "R12");
    // R9: data writes with and without sink ready
    op(0, 0, 1, 0, 8'h77, 0, 0, 8'h00, "R9");
    op(0, 0, 1, 0, 8'h88, 1, 0, 8'h00, "R9");
    // R10: data reads with and without a character
    op(0, 0, 0, 1, 8'h00, 0, 1, 8'hC3, "R10");
    op(0, 0, 0, 1, 8'h00, 0, 0, 8'hC3, "R10");
    // R11: all strobes together while the pointer is armed
    cwr(8'h03, "R2");
    op(1, 1, 1, 1, 8'h9E, 1, 1, 8'h11, "R11");
    cwr(8'h05, "R2");
    op(0, 1, 1, 1, 8'h9E, 1, 1, 8'h11, "R11");
    op(0, 0, 1, 1, 8'h6B, 1, 1, 8'h22, "R11");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] s;
      logic [7:0] v;
      s = 4'($urandom);
      v = 8'($urandom);
      if (($urandom % 4) == 0) v = {2'b00, 3'($urandom % 2), 3'($urandom)};
      if (($urandom % 50) == 0) stat_b[$urandom % 8] = 8'($urandom);
      op(s[0] & (($urandom % 2) == 0), s[1], s[2], s[3], v,
         1'($urandom), 1'($urandom), 8'($urandom), "R11");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule